// File: doc/BRIEF.md
# Status Word and Condition-Flag Unit

This block keeps the 16-bit processor status word of a small 16-bit core: one privilege bit (0 for supervisor, 1 for user), a 3-bit priority level and three one-hot sign flags that describe the last result written to a destination register. Each cycle the result bus may carry such a result together with the opcode that produced it. The flags follow that result only when the opcode belongs to the flag-setting group, which covers the arithmetic/logic operations and the four load forms. Every other opcode leaves them alone.

The unit also screens each fetched instruction. It raises an exception request when the opcode field holds the one unassigned value. It also raises one when a return-from-interrupt arrives while the core runs in user mode. Each request carries the 8-bit vector of its cause. The exception sequencer reads the status word when it enters or leaves a service routine, and writes a whole new status word through the load port. The sequencer, the datapath and memory lie outside this block.

Top module: `stat_word_unit`

## Requirements
- R1: While reset is high, at the next clock edge the status word becomes 0x0002 (supervisor, priority 0, zero flag set) and exc_req and exc_vec become 0.
- R2: With res_we high, ld_en low and a flag-setting opcode, the flags in bits [2:0] become one-hot one cycle later: 3'b100 for a negative result (bit 15 set), 3'b010 for zero and 3'b001 for a positive result. Bits [15:3] are unchanged.
- R3: The flag-setting opcodes are 0001, 0101, 1001, 0010, 1010, 0110 and 1110. A result written with any other opcode leaves the whole status word unchanged.
- R4: With ld_en high, one cycle later the status word equals ld_word with only bits 15, 10:8 and 2:0 kept and every other bit zero.
- R5: When ld_en and res_we are both high in the same cycle, the load wins and the result has no effect on the flags.
- R6: A valid instruction whose bits [15:12] are 1101 gives exc_req=1 and exc_vec=0x01 one cycle later, in either privilege mode.
- R7: A valid instruction with bits [15:12]=1000 gives exc_req=1 and exc_vec=0x00 one cycle later when status bit 15 was 1 in the cycle it was presented. In supervisor mode it raises nothing.
- R8: exc_req is 0 one cycle after a cycle with no valid instruction, or after a valid instruction that meets neither R6 nor R7. exc_vec reads 0 whenever exc_req is 0.
- R9: With res_we and ld_en both low, the status word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | insn holds a freshly fetched instruction |
| insn | input | 16 | Fetched instruction; bits [15:12] are the opcode |
| res_we | input | 1 | A result is being written to a destination register |
| res_op | input | 4 | Opcode of the instruction producing the result |
| res_data | input | 16 | Result value, two's complement |
| ld_en | input | 1 | Replace the status word |
| ld_word | input | 16 | New status word for the load |
| stat_word | output | 16 | Registered status word |
| exc_req | output | 1 | Registered exception request |
| exc_vec | output | 8 | Vector of the requested exception |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a 3-bit priority field and a 4-bit opcode field. With these defaults, all sixteen opcode values can be applied, both on the result port and on the instruction port. That makes the set of flag-setting opcodes and the two exception opcodes checkable in full. It also reaches the sign boundaries 0x7FFF, 0x8000, 0xFFFF and 0, and it brings out the ordering cases: a load and a result in the same cycle, and a load and a return instruction in the same cycle, where the mode before the load decides.

// File: rtl/swu_pkg.sv
package swu_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD  = 4'b0001,
    OPC_AND  = 4'b0101,
    OPC_NOT  = 4'b1001,
    OPC_LD   = 4'b0010,
    OPC_LDI  = 4'b1010,
    OPC_LDR  = 4'b0110,
    OPC_LEA  = 4'b1110,
    OPC_RET  = 4'b1000,
    OPC_HOLE = 4'b1101
  } opc_e;

  typedef enum int {
    CLS_FLAG    = 0,
    CLS_ILLEGAL = 1,
    CLS_RET     = 2
  } opc_class_e;

  localparam logic [7:0] VEC_PRIV    = 8'h00;
  localparam logic [7:0] VEC_ILLEGAL = 8'h01;
endpackage

// File: rtl/swu_op_class.sv
module swu_op_class
  import swu_pkg::*;
#(
  parameter int OP_W  = 4,
  parameter int CLASS = CLS_FLAG
) (
  input  logic [OP_W-1:0] op,
  output logic            hit
);
  generate
    if (CLASS == CLS_FLAG) begin : g_flag
      always_comb begin
        unique case (op)
          OPC_ADD, OPC_AND, OPC_NOT,
          OPC_LD, OPC_LDI, OPC_LDR, OPC_LEA: hit = 1'b1;
          default:                           hit = 1'b0;
        endcase
      end
    end else if (CLASS == CLS_ILLEGAL) begin : g_ill
      assign hit = (op == OPC_HOLE);
    end else begin : g_ret
      assign hit = (op == OPC_RET);
    end
  endgenerate
endmodule

// File: rtl/swu_flag_gen.sv
module swu_flag_gen #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] value,
  output logic [2:0]        flags
);
  logic is_neg;
  logic is_zero;

  assign is_neg  = value[DATA_W-1];
  assign is_zero = (value == '0);

  always_comb begin
    if (is_neg)       flags = 3'b100;
    else if (is_zero) flags = 3'b010;
    else              flags = 3'b001;
  end
endmodule

// File: rtl/swu_exc_screen.sv
module swu_exc_screen
  import swu_pkg::*;
#(
  parameter int OP_W  = 4,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [OP_W-1:0]  op,
  input  logic             user_mode,
  output logic             req,
  output logic [VEC_W-1:0] vec
);
  logic hole_hit;
  logic ret_hit;

  swu_op_class #(.OP_W(OP_W), .CLASS(CLS_ILLEGAL)) u_hole (.op(op), .hit(hole_hit));
  swu_op_class #(.OP_W(OP_W), .CLASS(CLS_RET))     u_ret  (.op(op), .hit(ret_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      vec <= '0;
    end else if (valid && hole_hit) begin
      req <= 1'b1;
      vec <= VEC_W'(VEC_ILLEGAL);
    end else if (valid && ret_hit && user_mode) begin
      req <= 1'b1;
      vec <= VEC_W'(VEC_PRIV);
    end else begin
      req <= 1'b0;
      vec <= '0;
    end
  end
endmodule

// File: rtl/stat_word_unit.sv
module stat_word_unit
  import swu_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int PRIO_W   = 3,
  parameter int PRIO_LSB = 8,
  parameter int OP_W     = 4,
  parameter int VEC_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_valid,
  input  logic [DATA_W-1:0] insn,
  input  logic              res_we,
  input  logic [OP_W-1:0]   res_op,
  input  logic [DATA_W-1:0] res_data,
  input  logic              ld_en,
  input  logic [DATA_W-1:0] ld_word,
  output logic [DATA_W-1:0] stat_word,
  output logic              exc_req,
  output logic [VEC_W-1:0]  exc_vec
);
  localparam int PRIV_BIT = DATA_W - 1;
  localparam int OP_LSB   = DATA_W - OP_W;
  localparam logic [DATA_W-1:0] PRIV_MASK = DATA_W'(1) << PRIV_BIT;
  localparam logic [DATA_W-1:0] PRIO_MASK = DATA_W'((1 << PRIO_W) - 1) << PRIO_LSB;
  localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(3'b111);
  localparam logic [DATA_W-1:0] DEF_MASK  = PRIV_MASK | PRIO_MASK | FLAG_MASK;
  localparam logic [DATA_W-1:0] RST_WORD  = DATA_W'(3'b010);

  logic [DATA_W-1:0] stat_q;
  logic [2:0]        new_flags;
  logic              flag_op;
  logic              unused_insn_low;

  assign unused_insn_low = ^insn[OP_LSB-1:0];

  swu_op_class #(.OP_W(OP_W), .CLASS(CLS_FLAG)) u_cls (
    .op  (res_op),
    .hit (flag_op)
  );

  swu_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .value (res_data),
    .flags (new_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= RST_WORD;
    end else if (ld_en) begin
      stat_q <= ld_word & DEF_MASK;
    end else if (res_we && flag_op) begin
      stat_q[2:0] <= new_flags;
    end
  end

  swu_exc_screen #(.OP_W(OP_W), .VEC_W(VEC_W)) u_exc (
    .clk       (clk),
    .rst       (rst),
    .valid     (insn_valid),
    .op        (insn[DATA_W-1:OP_LSB]),
    .user_mode (stat_q[PRIV_BIT]),
    .req       (exc_req),
    .vec       (exc_vec)
  );

  assign stat_word = stat_q;
endmodule

// File: rtl/swu_chk.sv
module swu_chk #(
  parameter int DATA_W   = 16,
  parameter int PRIO_W   = 3,
  parameter int PRIO_LSB = 8,
  parameter int OP_W     = 4,
  parameter int VEC_W    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              insn_valid,
  input logic [DATA_W-1:0] insn,
  input logic              res_we,
  input logic              ld_en,
  input logic [DATA_W-1:0] ld_word,
  input logic [DATA_W-1:0] stat_word,
  input logic              exc_req,
  input logic [VEC_W-1:0]  exc_vec
);
  localparam logic [DATA_W-1:0] KEEP =
    (DATA_W'(1) << (DATA_W-1)) | (DATA_W'((1 << PRIO_W) - 1) << PRIO_LSB) | DATA_W'(3'b111);
  localparam int OPL = DATA_W - OP_W;

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stat_word == DATA_W'(2) && !exc_req && exc_vec == '0));

  a_r4_undefined_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) || ((stat_word & ~KEEP) == '0));

  a_r5_load_wins: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ld_en)) |-> (stat_word == ($past(ld_word) & KEEP)));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ld_en) && !$past(res_we)) |-> $stable(stat_word));

  a_r6_illegal: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(insn_valid && insn[DATA_W-1:OPL] == 4'b1101))
      |-> (exc_req && exc_vec == VEC_W'(1)));

  a_r7_user_ret: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(insn_valid && insn[DATA_W-1:OPL] == 4'b1000 && stat_word[DATA_W-1]))
      |-> (exc_req && exc_vec == '0));

  a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(insn_valid)) |-> !exc_req);

  a_r8_vec_zero: assert property (@(posedge clk) disable iff (rst)
    !exc_req |-> (exc_vec == '0));
endmodule

bind stat_word_unit swu_chk #(
  .DATA_W(DATA_W), .PRIO_W(PRIO_W), .PRIO_LSB(PRIO_LSB), .OP_W(OP_W), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn(insn), .res_we(res_we),
  .ld_en(ld_en), .ld_word(ld_word), .stat_word(stat_word), .exc_req(exc_req),
  .exc_vec(exc_vec)
);

// File: tb/stat_word_unit_test.sv
`timescale 1ns/1ps
module stat_word_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_valid = 1'b0;
  logic [15:0] insn = '0;
  logic        res_we = 1'b0;
  logic [3:0]  res_op = '0;
  logic [15:0] res_data = '0;
  logic        ld_en = 1'b0;
  logic [15:0] ld_word = '0;
  logic [15:0] stat_word;
  logic        exc_req;
  logic [7:0]  exc_vec;

  always #10 clk = ~clk;

  stat_word_unit uut (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn(insn), .res_we(res_we),
    .res_op(res_op), .res_data(res_data), .ld_en(ld_en), .ld_word(ld_word),
    .stat_word(stat_word), .exc_req(exc_req), .exc_vec(exc_vec)
  );

  typedef struct {
    logic [15:0] st;
    logic        rq;
    logic [7:0]  vc;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          vectors = 0;
  int          miscompares = 0;
  bit          done = 1'b0;
  logic [15:0] m_stat = 16'h0002;

  function automatic logic [2:0] model_flags(input logic [15:0] v);
    if (v[15])        return 3'b100;
    else if (v == 0)  return 3'b010;
    else              return 3'b001;
  endfunction

  function automatic bit model_flag_op(input logic [3:0] op);
    return op inside {4'b0001, 4'b0101, 4'b1001, 4'b0010, 4'b1010, 4'b0110, 4'b1110};
  endfunction

  task automatic step(input logic iv, input logic [15:0] in,
                      input logic we, input logic [3:0] op, input logic [15:0] rd,
                      input logic ld, input logic [15:0] lw, input string tag);
    exp_t e;
    @(negedge clk);
    insn_valid = iv; insn = in; res_we = we; res_op = op; res_data = rd;
    ld_en = ld; ld_word = lw;
    e.rq = 1'b0; e.vc = 8'h00;
    if (iv && in[15:12] == 4'b1101) begin
      e.rq = 1'b1; e.vc = 8'h01;
    end else if (iv && in[15:12] == 4'b1000 && m_stat[15]) begin
      e.rq = 1'b1; e.vc = 8'h00;
    end
    if (ld)                             m_stat = lw & 16'h8707;
    else if (we && model_flag_op(op))   m_stat[2:0] = model_flags(rd);
    e.st = m_stat; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 16'h0000, 1'b0, 4'h0, 16'h0000, 1'b0, 16'h0000, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      vectors++;
      if (stat_word !== e.st || exc_req !== e.rq || exc_vec !== e.vc) begin
        miscompares++;
        $display("FAIL %s: got stat=%h req=%b vec=%h, expected stat=%h req=%b vec=%h",
                 e.tag, stat_word, exc_req, exc_vec, e.st, e.rq, e.vc);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    vectors++;
    if (stat_word !== 16'h0002 || exc_req !== 1'b0 || exc_vec !== 8'h00) begin
      miscompares++;
      $display("FAIL R1: got stat=%h req=%b vec=%h, expected stat=0002 req=0 vec=00",
               stat_word, exc_req, exc_vec);
    end
    idle("R1 idle after reset");

    // R2: sign boundaries with ADD
    step(0, 0, 1, 4'b0001, 16'h8000, 0, 0, "R2 neg 8000");
    step(0, 0, 1, 4'b0001, 16'h0000, 0, 0, "R2 zero");
    step(0, 0, 1, 4'b0001, 16'h7FFF, 0, 0, "R2 pos 7FFF");
    step(0, 0, 1, 4'b0001, 16'hFFFF, 0, 0, "R2 neg FFFF");
    step(0, 0, 1, 4'b0001, 16'h0001, 0, 0, "R2 pos 0001");

    // R3: every opcode, alternating values so each flag change is visible
    for (int k = 0; k < 16; k++) begin
      step(0, 0, 1, 4'(k), (k % 2 == 0) ? 16'h8123 : 16'h0000, 0, 0, "R3 opcode sweep");
      step(0, 0, 1, 4'(k), 16'h0042, 0, 0, "R3 opcode sweep pos");
    end

    // R9: no write, no load
    step(0, 0, 0, 4'b0001, 16'h8000, 0, 0, "R9 res_we low");
    idle("R9 idle");

    // R4: load with undefined bits set
    step(0, 0, 0, 0, 0, 1, 16'hFFFF, "R4 load FFFF");
    step(0, 0, 0, 0, 0, 1, 16'h7CF9, "R4 load 7CF9");
    step(0, 0, 0, 0, 0, 1, 16'h8401, "R4 load user prio4");

    // R5: load beats result in the same cycle
    step(0, 0, 1, 4'b0101, 16'h0000, 1, 16'h0304, "R5 load vs result");
    step(0, 0, 1, 4'b0101, 16'h0000, 0, 0, "R5 follow-up result");

    // R7: return in supervisor mode, then user mode
    step(1, 16'h8000, 0, 0, 0, 0, 0, "R7 ret supervisor");
    step(0, 0, 0, 0, 0, 1, 16'h8002, "R7 enter user");
    step(1, 16'h8000, 0, 0, 0, 0, 0, "R7 ret user");
    step(1, 16'h8000, 0, 0, 0, 1, 16'h0002, "R7 ret with load to supervisor");
    step(1, 16'h8000, 0, 0, 0, 0, 0, "R7 ret after load");

    // R6: unassigned opcode in both modes
    step(1, 16'hD123, 0, 0, 0, 0, 0, "R6 illegal supervisor");
    step(1, 16'hDFFF, 0, 0, 0, 1, 16'h8001, "R6 illegal, load user");
    step(1, 16'hD000, 0, 0, 0, 0, 0, "R6 illegal user");

    // R8: no exception for other opcodes or when not valid
    for (int k = 0; k < 16; k++)
      step(1, {4'(k), 12'h0A5}, 0, 0, 0, 0, 0, "R8 R6 R7 insn sweep user");
    step(0, 16'hD000, 0, 0, 0, 0, 0, "R8 invalid illegal");
    step(0, 16'h8000, 0, 0, 0, 0, 0, "R8 invalid ret");
    idle("R8 idle");

    @(posedge clk);
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule